// File: doc/BRIEF.md
# Group-Bypass Carry-Skip Adder

A purely combinational adder for two unsigned operands and a carry input. It returns the truncated sum and a carry output. The operand bits are split into equal groups, and each group is a short chain of full-adder cells that pass the carry along one bit at a time.

Next to each chain, the group works out whether every one of its bits would pass an incoming carry straight through. In that case a multiplexer sends the group's carry input directly to its carry output, so the carry does not have to travel through the group's cells. Otherwise the group's carry output comes from its own chain, where the carry was either produced or absorbed inside the group.

The operand width and the group size are parameters. The defaults are 16 bits in four groups of 4. Elaboration stops with an error if the width is not a whole multiple of the group size.

Top module: `csk_adder`

## Requirements
- R1: For every operand pair and carry input, {cout, sum} equals opa + opb + cin taken as unsigned numbers, so cout is bit WIDTH of the full result.
- R2: For each bit, exactly one of three per-bit terms is true. Generate is opa AND opb. Propagate is opa XOR opb. Kill means both operand bits are 0. Generate adds a carry into the next higher bit, and kill passes none.
- R3: A group whose bits all propagate (the AND of its propagate terms is 1) forwards its carry input unchanged to its carry output. With opa XOR opb all ones, cout equals cin.
- R4: In a group where not every bit propagates, the carry output does not depend on the group's carry input. It is 1 exactly when the group's own bits, added with no carry in, overflow the group width.
- R5: The sum bits of each group are formed from the carry that actually enters that group. This includes a carry that was forwarded past lower groups.
- R6: The adder's carry output is the carry output of the most significant group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input  | WIDTH | First unsigned operand |
| opb  | input  | WIDTH | Second unsigned operand |
| cin  | input  | 1     | Carry into bit 0 |
| sum  | output | WIDTH | Low WIDTH bits of opa + opb + cin |
| cout | output | 1     | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that enters at bit 0 and is forwarded through every group. This happens only when each operand bit pair differs, and random operands almost never do that. The stimulus therefore builds operand pairs whose XOR is all ones, using both cin values. It also uses pairs where exactly one group breaks the chain, so that the sum bits above the break show whether the forwarded carry arrived. To show that a group's carry output ignores its carry input, the same operands are applied with cin at 0 and then at 1, and cout must not change.

// File: rtl/csk_pkg.sv
package csk_pkg;

  // Per-bit carry behaviour terms; exactly one is set for any bit pair.
  typedef struct packed {
    logic gen;
    logic prop;
    logic kill;
  } pgk_t;

endpackage

// File: rtl/csk_pgk_cell.sv
module csk_pgk_cell
  import csk_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  output pgk_t pgk_o
);

  always_comb begin
    pgk_o.gen  = a_i & b_i;
    pgk_o.prop = a_i ^ b_i;
    pgk_o.kill = ~(a_i | b_i);
  end

endmodule

// File: rtl/csk_fa_cell.sv
module csk_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  // Majority carry and three-input parity sum.
  assign c_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
  assign s_o = a_i ^ b_i ^ c_i;

endmodule

// File: rtl/csk_group.sv
module csk_group
  import csk_pkg::*;
#(
  parameter int GRP = 4
) (
  input  logic             [GRP-1:0] a_i,
  input  logic             [GRP-1:0] b_i,
  input  logic                       c_i,
  output logic             [GRP-1:0] s_o,
  output logic                       c_o,
  output logic                       skip_o,
  output pgk_t             [GRP-1:0] pgk_o
);

  logic [GRP:0]   chain;
  logic [GRP-1:0] prop_v;
  logic           chain_out;

  assign chain[0] = c_i;

  for (genvar bi = 0; bi < GRP; bi++) begin : g_bit
    csk_pgk_cell u_pgk (
      .a_i   (a_i[bi]),
      .b_i   (b_i[bi]),
      .pgk_o (pgk_o[bi])
    );

    assign prop_v[bi] = pgk_o[bi].prop;

    csk_fa_cell u_fa (
      .a_i (a_i[bi]),
      .b_i (b_i[bi]),
      .c_i (chain[bi]),
      .s_o (s_o[bi]),
      .c_o (chain[bi+1])
    );
  end

  assign chain_out = chain[GRP];

  // Whole group passes a carry: forward the input, skipping the chain.
  assign skip_o = &prop_v;

  always_comb begin
    if (skip_o) c_o = c_i;
    else        c_o = chain_out;
  end

endmodule

// File: rtl/csk_adder.sv
module csk_adder
  import csk_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NGRP = WIDTH / GRP;

  if ((GRP < 1) || (WIDTH % GRP != 0)) begin : g_param_err
    $error("csk_adder: WIDTH must be a positive multiple of GRP");
  end

  logic [NGRP:0]          grp_carry;
  logic [NGRP-1:0]        grp_skip;
  pgk_t [WIDTH-1:0]       pgk_all;

  assign grp_carry[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    csk_group #(.GRP(GRP)) u_grp (
      .a_i    (opa[gi*GRP +: GRP]),
      .b_i    (opb[gi*GRP +: GRP]),
      .c_i    (grp_carry[gi]),
      .s_o    (sum[gi*GRP +: GRP]),
      .c_o    (grp_carry[gi+1]),
      .skip_o (grp_skip[gi]),
      .pgk_o  (pgk_all[gi*GRP +: GRP])
    );
  end

  assign cout = grp_carry[NGRP];

endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk
  import csk_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input logic [WIDTH-1:0]       opa,
  input logic [WIDTH-1:0]       opb,
  input logic                   cin,
  input logic [WIDTH-1:0]       sum,
  input logic                   cout,
  input logic [WIDTH/GRP:0]     grp_carry,
  input logic [WIDTH/GRP-1:0]   grp_skip,
  input pgk_t [WIDTH-1:0]       pgk_all
);

  localparam int NGRP = WIDTH / GRP;

  logic [WIDTH:0] ref_full;
  assign ref_full = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    // R1
    sum_value_chk: assert ({cout, sum} == ref_full)
      else $error("R1 sum mismatch");
    // R6
    top_carry_chk: assert (cout == grp_carry[NGRP])
      else $error("R6 carry out mismatch");
    for (int bi = 0; bi < WIDTH; bi++) begin
      // R2
      pgk_onehot_chk: assert ($countones({pgk_all[bi].gen, pgk_all[bi].prop, pgk_all[bi].kill}) == 1)
        else $error("R2 per-bit terms not one-hot");
    end
    for (int gi = 0; gi < NGRP; gi++) begin
      // R3
      skip_pass_chk: assert (!grp_skip[gi] || (grp_carry[gi+1] == grp_carry[gi]))
        else $error("R3 skipped group altered carry");
      // R4
      local_carry_chk: assert (grp_skip[gi] ||
          (grp_carry[gi+1] == (((opa >> (gi*GRP)) & ((1 << GRP) - 1)) +
                               ((opb >> (gi*GRP)) & ((1 << GRP) - 1)) >= (1 << GRP))))
        else $error("R4 group carry depends on carry in");
    end
  end

endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) i_csk_adder_chk (
  .opa       (opa),
  .opb       (opb),
  .cin       (cin),
  .sum       (sum),
  .cout      (cout),
  .grp_carry (grp_carry),
  .grp_skip  (grp_skip),
  .pgk_all   (pgk_all)
);

// File: tb/test_csk_adder.sv
`timescale 1ns/1ps
module test_csk_adder;

  localparam int WIDTH = 16;
  localparam int GRP   = 4;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] opa, opb, sum;
  logic             cin, cout;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  csk_adder #(.WIDTH(WIDTH), .GRP(GRP)) i_csk_adder (
    .opa  (opa),
    .opb  (opb),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply at the rising edge, compare against the behavioural sum at the falling edge.
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic c, input string tag);
    logic [WIDTH:0] expv;
    @(posedge clk);
    opa = a; opb = b; cin = c;
    expv = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
    @(negedge clk);
    check({cout, sum} == expv, tag, {47'd0, cout, sum}, {47'd0, expv});
  endtask

  task automatic cout_same(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                           input logic expc);
    logic c0;
    apply(a, b, 1'b0, "R4 cin=0");
    c0 = cout;
    apply(a, b, 1'b1, "R4 cin=1");
    check((cout == c0) && (cout == expc), "R4 cout independent of cin",
          {63'd0, cout}, {63'd0, expc});
  endtask

  initial begin
    rst_n = 1'b0;
    opa = '0; opb = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check((sum == '0) && (cout == 1'b0), "R1 zero inputs at reset",
          {47'd0, cout, sum}, 64'd0);
    rst_n = 1'b1;

    apply('0, '0, 1'b0, "R1 all zeros");
    apply('0, '0, 1'b1, "R1 zeros plus carry");
    apply('1, '0, 1'b1, "R3 full propagate chain");
    check(cout == 1'b1, "R3 cout follows cin=1", {63'd0, cout}, 64'd1);
    apply('1, '0, 1'b0, "R3 full propagate cin=0");
    check(cout == 1'b0, "R3 cout follows cin=0", {63'd0, cout}, 64'd0);
    apply(16'hAAAA, 16'h5555, 1'b1, "R3 alternating propagate");
    check(cout == 1'b1, "R6 carry forwarded to top", {63'd0, cout}, 64'd1);
    apply(16'hAAAA, 16'hAAAA, 1'b0, "R1 alternating equal");
    apply(16'h5555, 16'h5555, 1'b1, "R1 alternating equal cin");
    apply('1, '1, 1'b1, "R1 all ones both");

    for (int bi = 0; bi < WIDTH; bi++) begin
      apply(WIDTH'(1) << bi, WIDTH'(1) << bi, 1'b0, "R2 single generate");
      apply(WIDTH'(1) << bi, '0, 1'b0, "R2 single propagate");
    end
    apply(16'h0F0F, 16'hF0F0 & 16'h0000, 1'b0, "R2 kill holds zero");

    // R5: group 0 forwards, sum above shows the forwarded carry
    apply(16'h000F, 16'h0000, 1'b1, "R5 forwarded into group1");
    check(sum == 16'h0010, "R5 group1 sum bit", {48'd0, sum}, 64'h10);
    apply(16'h00FF, 16'h0000, 1'b1, "R5 forwarded two groups");
    check(sum == 16'h0100, "R5 group2 sum bit", {48'd0, sum}, 64'h100);
    apply(16'h0F0F, 16'h0000, 1'b1, "R5 chain broken at group1");
    check(sum == 16'h0F10, "R5 broken chain sum", {48'd0, sum}, 64'h0F10);

    cout_same(16'hF000, 16'h1000, 1'b1);
    cout_same(16'h0FFF, 16'h0000, 1'b0);
    cout_same(16'h8FFF, 16'h8000, 1'b1);

    for (int n = 0; n < 10000; n++) begin
      apply(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), "R1 random");
    end
    for (int n = 0; n < 200; n++) begin
      logic [WIDTH-1:0] r;
      r = WIDTH'($urandom);
      apply(r, ~r, 1'($urandom), "R3 random full propagate");
      check(cout == cin, "R6 propagate cout", {63'd0, cout}, {63'd0, cin});
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule